// File: doc/BRIEF.md
# LPC Host Byte-Cycle Engine

This block is the host end of a Low Pin Count bus. A single upstream request carries a read or a write, to memory space or I/O space, of 1, 2 or 4 bytes. The engine runs one single-byte bus cycle for each byte of that request, in ascending address order. Each bus cycle goes through frame strobe and start nibble, the cycle-type nibble, the address nibbles, write data if any, a turnaround, SYNC sampling, read data if any, and a closing turnaround. Read bytes are packed into byte lanes of a full-width response. The requester gets one acknowledge after the final byte cycle.

A peripheral that never answers with a valid SYNC does not stall the bus. After a short no-response window the host drives an abort and records the byte as 0xFF, so an unclaimed read completes with all-ones data and not with an error. Memory requests at or above the 16 MB boundary are refused at the request port and cause no bus activity. Requests with the reserved size code are refused the same way.

The LAD bus is modelled as separate output, output-enable and input nibbles. The pad and its pull-ups sit outside this block.

Top module: `lpc_byte_host`

## Requirements
- R1: After reset and while idle: `lframe_n` is high, `lad_oe` is low, `req_ready` is high, and `ack` and `req_reject` are low.
- R2: Each byte cycle opens with exactly one clock of `lframe_n` low with LAD = 0000. The next clock carries the type nibble: bits [3:2] = 00 for I/O or 01 for memory, bit 1 = 1 for a write, bit 0 = 0.
- R3: The address follows the type nibble, most significant nibble first. I/O cycles send 4 nibbles (the low 16 address bits) and memory cycles send 8 nibbles. A write then sends its data byte low nibble first. The host next drives 1111 for one clock and then releases LAD for one clock before SYNC.
- R4: `req_size` selects 1 byte (0), 2 bytes (1) or 4 bytes (2). The request becomes that many back-to-back byte cycles at addresses base, base+1, and so on. Write byte i is taken from `req_wdata[8i+7:8i]`.
- R5: During SYNC, 0000 means ready. 0101 and 0110 are waits: they hold the cycle and restart the no-response count. Any other nibble counts as no response. The third counted clock in a row ends the cycle as unclaimed.
- R6: An unclaimed cycle is aborted by holding `lframe_n` low with LAD = 1111 for 4 clocks. The next byte cycle then starts.
- R7: A claimed read byte arrives after ready, low nibble first, and lands in lane i of `rsp_rdata`. An unclaimed byte reads as 0xFF. Lanes beyond the request size read as zero.
- R8: `ack` is a single-clock pulse, issued exactly once per accepted request and only after its final byte cycle, with `rsp_rdata` valid in that clock. `req_ready` is low from acceptance through the acknowledge.
- R9: A memory request with base address at or above 2^24, or with `req_size` = 3, is refused. `req_reject` pulses in the clock after acceptance, and there is no bus activity and no `ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Upstream request present |
| req_ready | output | 1 | Engine idle; request accepted when valid and ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved |
| req_addr | input | 32 | Byte address of the lowest byte |
| req_wdata | input | 32 | Write data, byte i in lane i |
| ack | output | 1 | Request complete pulse |
| rsp_rdata | output | 32 | Read data, valid with ack |
| req_reject | output | 1 | Request refused pulse |
| lframe_n | output | 1 | Frame strobe, active low |
| lad_out | output | 4 | LAD value driven by the host |
| lad_oe | output | 1 | Host drives LAD when high |
| lad_in | input | 4 | LAD value seen on the bus |

## Verification
The SYNC wait decoder and the no-response expiry can act in the same clock: a wait nibble may arrive exactly when the count would otherwise run out. The bench peripheral has a script for this case. It leaves two idle clocks, sends one wait, leaves two more idle clocks and then sends ready, so a wait that fails to restart the count would abort the cycle. The bench judges the outcome by the abort count on the bus and by the returned read bytes, which must be the peripheral's data and not 0xFF.

// File: rtl/lpc_host_pkg.sv
package lpc_host_pkg;

   typedef enum logic [3:0] {
      ST_IDLE, ST_START, ST_CTYPE, ST_ADDR, ST_WDAT, ST_TAR1, ST_TAR2,
      ST_SYNC, ST_RDAT, ST_TARB, ST_ABORT, ST_DONE, ST_REJ
   } lpc_state_e;

   localparam logic [3:0] NIB_START   = 4'h0;
   localparam logic [3:0] NIB_ABORT   = 4'hF;
   localparam logic [3:0] NIB_RELEASE = 4'hF;
   localparam logic [3:0] SYNC_READY  = 4'h0;
   localparam logic [3:0] SYNC_SHORT  = 4'h5;
   localparam logic [3:0] SYNC_LONG   = 4'h6;

   function automatic logic [3:0] ctype_nib(input logic is_mem, input logic is_wr);
      return {1'b0, is_mem, is_wr, 1'b0};
   endfunction

endpackage

// File: rtl/lpc_nib_sel.sv
module lpc_nib_sel #(
   parameter int ADDR_W   = 32,
   parameter int IO_NIBS  = 4,
   parameter int MEM_NIBS = 8,
   parameter int CNT_W    = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              is_mem,
   input  logic [CNT_W-1:0]  idx,
   output logic [3:0]        nib,
   output logic              last
);
   int nibs;
   int pos;

   always_comb begin
      nibs = is_mem ? MEM_NIBS : IO_NIBS;
      pos  = nibs - 1 - int'(idx);
      nib  = 4'h0;
      for (int k = 0; k < MEM_NIBS; k++) begin
         if (k == pos) nib = addr[4*k +: 4];
      end
      last = (int'(idx) == nibs - 1);
   end
endmodule

// File: rtl/lpc_sync_det.sv
module lpc_sync_det
   import lpc_host_pkg::*;
#(
   parameter int TIMEOUT = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       active,
   input  logic [3:0] lad_in,
   output logic       ready,
   output logic       expired
);
   localparam int CW = $clog2(TIMEOUT + 1);

   logic [CW-1:0] idle_cnt;
   logic          is_wait;
   logic          is_none;

   always_comb begin
      is_wait = (lad_in == SYNC_SHORT) || (lad_in == SYNC_LONG);
      ready   = active && (lad_in == SYNC_READY);
      is_none = active && !ready && !is_wait;
      expired = is_none && (idle_cnt == CW'(TIMEOUT - 1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !active || is_wait) idle_cnt <= '0;
      else if (is_none && !expired)     idle_cnt <= idle_cnt + CW'(1);
   end
endmodule

// File: rtl/lpc_rd_lanes.sv
module lpc_rd_lanes #(
   parameter int NBYTES = 4,
   parameter int IDX_W  = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clear,
   input  logic                  we,
   input  logic [IDX_W-1:0]      lane,
   input  logic [7:0]            wbyte,
   output logic [8*NBYTES-1:0]   data
);
   for (genvar g = 0; g < NBYTES; g++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n || clear)                     data[8*g +: 8] <= 8'h00;
         else if (we && lane == IDX_W'(g))        data[8*g +: 8] <= wbyte;
      end
   end
endmodule

// File: rtl/lpc_byte_host.sv
module lpc_byte_host
   import lpc_host_pkg::*;
#(
   parameter int ADDR_W         = 32,
   parameter int DATA_W         = 32,
   parameter int MEM_SPACE_LOG2 = 24,
   parameter int IO_NIBS        = 4,
   parameter int MEM_NIBS       = 8,
   parameter int SYNC_TIMEOUT   = 3,
   parameter int ABORT_LEN      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_mem,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              ack,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              req_reject,
   output logic              lframe_n,
   output logic [3:0]        lad_out,
   output logic              lad_oe,
   input  logic [3:0]        lad_in
);
   localparam int NBYTES = DATA_W / 8;
   localparam int BIDX_W = $clog2(NBYTES);
   localparam int NCNT_W = $clog2(MEM_NIBS);
   localparam int ACNT_W = $clog2(ABORT_LEN + 1);

   if (DATA_W != 32) begin : g_bad_dw
      $error("DATA_W must be 32");
   end
   if (MEM_NIBS * 4 > ADDR_W || IO_NIBS > MEM_NIBS || IO_NIBS < 1) begin : g_bad_nibs
      $error("nibble counts do not fit the address width");
   end
   if (SYNC_TIMEOUT < 1 || ABORT_LEN < 1) begin : g_bad_cnt
      $error("SYNC_TIMEOUT and ABORT_LEN must be positive");
   end

   // Memory-space limit: a parameter picks whether any upper bits exist
   logic addr_high;
   if (MEM_SPACE_LOG2 >= ADDR_W) begin : g_no_limit
      assign addr_high = 1'b0;
   end else begin : g_limit
      assign addr_high = |req_addr[ADDR_W-1:MEM_SPACE_LOG2];
   end

   lpc_state_e         state;
   logic [ADDR_W-1:0]  addr_q;
   logic [DATA_W-1:0]  wdata_q;
   logic               wr_q, mem_q;
   logic [BIDX_W-1:0]  byte_idx, last_idx_q;
   logic [NCNT_W-1:0]  nib_cnt;
   logic [ACNT_W-1:0]  abort_cnt;
   logic [3:0]         rd_lo;

   logic [ADDR_W-1:0]  cur_addr;
   logic [7:0]         wbyte;
   logic [3:0]         addr_nib;
   logic               addr_last;
   logic               sync_ready, sync_expired;
   logic               req_bad, byte_last;
   logic               lane_we, lane_clr;
   logic [7:0]         lane_byte;

   assign cur_addr  = addr_q + ADDR_W'(byte_idx);
   assign wbyte     = wdata_q[8*byte_idx +: 8];
   assign req_bad   = (req_mem && addr_high) || (req_size == 2'b11);
   assign byte_last = (byte_idx == last_idx_q);

   lpc_nib_sel #(
      .ADDR_W(ADDR_W), .IO_NIBS(IO_NIBS), .MEM_NIBS(MEM_NIBS), .CNT_W(NCNT_W)
   ) u_nib (
      .addr(cur_addr), .is_mem(mem_q), .idx(nib_cnt), .nib(addr_nib), .last(addr_last)
   );

   lpc_sync_det #(.TIMEOUT(SYNC_TIMEOUT)) u_sync (
      .clk(clk), .rst_n(rst_n), .active(state == ST_SYNC), .lad_in(lad_in),
      .ready(sync_ready), .expired(sync_expired)
   );

   assign lane_clr  = (state == ST_IDLE) && req_valid;
   assign lane_we   = ((state == ST_RDAT) && nib_cnt[0]) ||
                      ((state == ST_SYNC) && sync_expired && !wr_q);
   assign lane_byte = (state == ST_RDAT) ? {lad_in, rd_lo} : 8'hFF;

   lpc_rd_lanes #(.NBYTES(NBYTES), .IDX_W(BIDX_W)) u_lanes (
      .clk(clk), .rst_n(rst_n), .clear(lane_clr), .we(lane_we),
      .lane(byte_idx), .wbyte(lane_byte), .data(rsp_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         addr_q     <= '0;
         wdata_q    <= '0;
         wr_q       <= 1'b0;
         mem_q      <= 1'b0;
         byte_idx   <= '0;
         last_idx_q <= '0;
         nib_cnt    <= '0;
         abort_cnt  <= '0;
         rd_lo      <= 4'h0;
      end else begin
         unique case (state)
            ST_IDLE: if (req_valid) begin
               addr_q   <= req_addr;
               wdata_q  <= req_wdata;
               wr_q     <= req_write;
               mem_q    <= req_mem;
               byte_idx <= '0;
               case (req_size)
                  2'd0:    last_idx_q <= BIDX_W'(0);
                  2'd1:    last_idx_q <= BIDX_W'(1);
                  default: last_idx_q <= BIDX_W'(3);
               endcase
               state <= req_bad ? ST_REJ : ST_START;
            end
            ST_START: state <= ST_CTYPE;
            ST_CTYPE: begin
               nib_cnt <= '0;
               state   <= ST_ADDR;
            end
            ST_ADDR: if (addr_last) begin
               nib_cnt <= '0;
               state   <= wr_q ? ST_WDAT : ST_TAR1;
            end else begin
               nib_cnt <= nib_cnt + NCNT_W'(1);
            end
            ST_WDAT: if (nib_cnt[0]) begin
               nib_cnt <= '0;
               state   <= ST_TAR1;
            end else begin
               nib_cnt <= NCNT_W'(1);
            end
            ST_TAR1: state <= ST_TAR2;
            ST_TAR2: state <= ST_SYNC;
            ST_SYNC: if (sync_ready) begin
               nib_cnt <= '0;
               state   <= wr_q ? ST_TARB : ST_RDAT;
            end else if (sync_expired) begin
               abort_cnt <= '0;
               state     <= ST_ABORT;
            end
            ST_RDAT: if (!nib_cnt[0]) begin
               rd_lo   <= lad_in;
               nib_cnt <= NCNT_W'(1);
            end else begin
               nib_cnt <= '0;
               state   <= ST_TARB;
            end
            ST_TARB: if (nib_cnt[0]) begin
               nib_cnt <= '0;
               if (byte_last) state <= ST_DONE;
               else begin
                  byte_idx <= byte_idx + BIDX_W'(1);
                  state    <= ST_START;
               end
            end else begin
               nib_cnt <= NCNT_W'(1);
            end
            ST_ABORT: if (abort_cnt == ACNT_W'(ABORT_LEN - 1)) begin
               if (byte_last) state <= ST_DONE;
               else begin
                  byte_idx <= byte_idx + BIDX_W'(1);
                  state    <= ST_START;
               end
            end else begin
               abort_cnt <= abort_cnt + ACNT_W'(1);
            end
            ST_DONE: state <= ST_IDLE;
            ST_REJ:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      req_ready  = (state == ST_IDLE);
      ack        = (state == ST_DONE);
      req_reject = (state == ST_REJ);
      lframe_n   = !((state == ST_START) || (state == ST_ABORT));
      lad_oe     = 1'b0;
      lad_out    = NIB_RELEASE;
      unique case (state)
         ST_START: begin lad_oe = 1'b1; lad_out = NIB_START; end
         ST_CTYPE: begin lad_oe = 1'b1; lad_out = ctype_nib(mem_q, wr_q); end
         ST_ADDR:  begin lad_oe = 1'b1; lad_out = addr_nib; end
         ST_WDAT:  begin lad_oe = 1'b1; lad_out = nib_cnt[0] ? wbyte[7:4] : wbyte[3:0]; end
         ST_TAR1:  begin lad_oe = 1'b1; lad_out = NIB_RELEASE; end
         ST_ABORT: begin lad_oe = 1'b1; lad_out = NIB_ABORT; end
         default:  ;
      endcase
   end
endmodule

// File: rtl/lpc_byte_host_chk.sv
module lpc_byte_host_chk #(
   parameter int ADDR_W         = 32,
   parameter int MEM_SPACE_LOG2 = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_mem,
   input logic [1:0]        req_size,
   input logic [ADDR_W-1:0] req_addr,
   input logic              ack,
   input logic              req_reject,
   input logic              lframe_n,
   input logic [3:0]        lad_out,
   input logic              lad_oe
);
   localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(1) << MEM_SPACE_LOG2;

   logic bad_req;
   assign bad_req = (req_mem && ({1'b0, req_addr} >= LIMIT)) || (req_size == 2'b11);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (lframe_n && !lad_oe)); // R1
   AST_FRAME_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lframe_n) |-> (lad_oe && (lad_out == 4'h0 || lad_out == 4'hF))); // R2
   AST_START_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      (!lframe_n && lad_out == 4'h0) |=> lframe_n); // R2
   AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack); // R8
   AST_ACK_REJ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack && req_reject)); // R8
   AST_BAD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && bad_req) |=> (req_reject && lframe_n)); // R9
   AST_GOOD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !bad_req) |=> (!req_reject && !lframe_n)); // R9
endmodule

bind lpc_byte_host lpc_byte_host_chk #(
   .ADDR_W(ADDR_W), .MEM_SPACE_LOG2(MEM_SPACE_LOG2)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_mem(req_mem), .req_size(req_size), .req_addr(req_addr), .ack(ack),
   .req_reject(req_reject), .lframe_n(lframe_n), .lad_out(lad_out), .lad_oe(lad_oe)
);

// File: tb/tb_lpc_byte_host.sv
module tb_lpc_byte_host;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic        req_ready, ack, req_reject, lframe_n, lad_oe;
   logic [31:0] rsp_rdata;
   logic [3:0]  lad_out;
   logic [3:0]  lad_in = 4'hF;

   always #5 clk = ~clk;

   lpc_byte_host dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_mem(req_mem), .req_size(req_size),
      .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rsp_rdata(rsp_rdata),
      .req_reject(req_reject), .lframe_n(lframe_n), .lad_out(lad_out),
      .lad_oe(lad_oe), .lad_in(lad_in)
   );

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   // Peripheral model: decodes the bus at falling edges, answers SYNC per script
   int          pmode = 0;   // 0 claimed with waits, 1 unclaimed, 2 late ready
   int          pwaits = 0;
   int          rel = -1;
   int          p_n = 4;
   int          s0 = 0;
   int          rdy = 0;
   logic [3:0]  p_ct = 4'h0;
   logic [31:0] p_addr = '0;
   logic [7:0]  p_wd = 8'h00;
   logic [3:0]  ob_ct [64];
   logic [31:0] ob_addr [64];
   logic [7:0]  ob_wd [64];
   int          nobs = 0;
   int          naborts = 0;
   int          tar_bad = 0;

   always @(negedge clk) begin
      lad_in = 4'hF;
      if (rst_n) begin
         if (!lframe_n && lad_oe && lad_out == 4'hF) naborts++;
         if (!lframe_n && lad_oe && lad_out == 4'h0) rel = 0;
         else if (rel >= 0) rel++;
         if (rel == 1) begin
            p_ct   = lad_out;
            p_n    = p_ct[2] ? 8 : 4;
            p_addr = '0;
         end
         if (rel >= 2 && rel <= p_n + 1) p_addr = {p_addr[27:0], lad_out};
         if (rel >= 2 && p_ct[1] && rel == p_n + 2) p_wd[3:0] = lad_out;
         if (rel >= 2 && p_ct[1] && rel == p_n + 3) p_wd[7:4] = lad_out;
         if (rel >= 2) begin
            s0 = 4 + p_n + (p_ct[1] ? 2 : 0);
            if (rel == s0 - 2 && !(lad_oe && lad_out == 4'hF)) tar_bad++;
            if (rel == s0 - 1 && lad_oe) tar_bad++;
            if (rel >= s0) begin
               int idx;
               idx = rel - s0;
               if (idx == 0) begin
                  ob_ct[nobs % 64]   = p_ct;
                  ob_addr[nobs % 64] = p_addr;
                  ob_wd[nobs % 64]   = p_wd;
                  nobs++;
               end
               rdy = (pmode == 2) ? 5 : pwaits;
               if (pmode == 0) begin
                  if (idx < pwaits) lad_in = (idx % 2 == 1) ? 4'h5 : 4'h6;
                  else if (idx == pwaits) lad_in = 4'h0;
               end else if (pmode == 2) begin
                  if (idx == 2) lad_in = 4'h5;
                  else if (idx == 5) lad_in = 4'h0;
               end
               if (pmode != 1 && !p_ct[1]) begin
                  if (idx == rdy + 1) lad_in = p_addr[3:0] ^ 4'hA;
                  if (idx == rdy + 2) lad_in = p_addr[7:4] ^ 4'h5;
               end
            end
         end
      end
   end

   function automatic logic [31:0] exp_rd(input logic [31:0] a, input int n, input int mode);
      logic [31:0] r;
      logic [31:0] t;
      r = '0;
      for (int i = 0; i < 4; i++) begin
         t = a + 32'(i);
         if (i < n) r[8*i +: 8] = (mode == 1) ? 8'hFF : (t[7:0] ^ 8'h5A);
      end
      return r;
   endfunction

   task automatic run_req(input logic wr, input logic mem, input logic [31:0] addr,
                          input logic [1:0] size, input logic [31:0] wd,
                          input int mode, input int waits);
      int n, nobs0, nab0, tar0, acks, rejs, bytes_at, post;
      logic bad, seen;
      logic [31:0] rd, ea;
      n    = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
      bad  = (mem && addr >= 32'h0100_0000) || (size == 2'd3);
      @(negedge clk);
      pmode = mode; pwaits = waits;
      nobs0 = nobs; nab0 = naborts; tar0 = tar_bad;
      acks = 0; rejs = 0; bytes_at = 0; post = 0; seen = 1'b0; rd = '0;
      req_valid = 1'b1; req_write = wr; req_mem = mem; req_addr = addr;
      req_size = size; req_wdata = wd;
      for (int c = 0; c < 3000 && post < 6; c++) begin
         @(negedge clk);
         req_valid = 1'b0;
         if (ack) begin acks++; bytes_at = nobs - nobs0; rd = rsp_rdata; seen = 1'b1; end
         if (req_reject) begin rejs++; seen = 1'b1; end
         if (seen) post++;
      end
      if (bad) begin
         check("R9", "reject pulses", 32'(rejs), 32'd1);
         check("R9", "no ack on reject", 32'(acks), 32'd0);
         check("R9", "no bus cycles on reject", 32'(nobs - nobs0), 32'd0);
      end else begin
         check("R8", "ack count", 32'(acks), 32'd1);
         check("R8", "bytes done at ack", 32'(bytes_at), 32'(n));
         check("R9", "no reject", 32'(rejs), 32'd0);
         check("R4", "byte cycles", 32'(nobs - nobs0), 32'(n));
         check("R6", "abort clocks", 32'(naborts - nab0), (mode == 1) ? 32'(4 * n) : 32'd0);
         check("R3", "turnaround faults", 32'(tar_bad - tar0), 32'd0);
         for (int i = 0; i < n && i < nobs - nobs0; i++) begin
            ea = addr + 32'(i);
            if (!mem) ea = ea & 32'h0000_FFFF;
            check("R2", "type nibble", 32'(ob_ct[(nobs0 + i) % 64]), {28'd0, 1'b0, mem, wr, 1'b0});
            check("R3", "byte address", ob_addr[(nobs0 + i) % 64], ea);
            if (wr) check("R4", "write byte", 32'(ob_wd[(nobs0 + i) % 64]), 32'(wd[8*i +: 8]));
         end
         if (!wr) check(mode == 2 ? "R5" : "R7", "read data", rd, exp_rd(addr, n, mode));
      end
      check("R8", "ready after completion", 32'(req_ready), 32'd1);
   endtask

   initial begin
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      check("R1", "lframe_n in reset", 32'(lframe_n), 32'd1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "idle frame/oe/ready/ack/reject",
            {27'd0, lframe_n, lad_oe, req_ready, ack, req_reject}, 32'b10100);

      run_req(1'b0, 1'b0, 32'h0000_0060, 2'd0, 32'h0, 0, 0);        // I/O byte read
      run_req(1'b0, 1'b1, 32'h0012_3450, 2'd2, 32'h0, 1, 0);        // R7: all-ones
      run_req(1'b1, 1'b1, 32'h00FF_FFFE, 2'd1, 32'hBEEF_A55A, 0, 2);// write with waits
      run_req(1'b0, 1'b0, 32'h0000_0380, 2'd2, 32'h0, 2, 0);        // R5: wait at expiry
      run_req(1'b0, 1'b1, 32'h0100_0000, 2'd0, 32'h0, 0, 0);        // R9: at boundary
      run_req(1'b0, 1'b1, 32'h00FF_FFFF, 2'd0, 32'h0, 0, 1);        // just below boundary
      run_req(1'b1, 1'b0, 32'h0000_0010, 2'd3, 32'h0, 0, 0);        // R9: reserved size
      run_req(1'b1, 1'b0, 32'hABCD_FFFE, 2'd2, 32'h1122_3344, 1, 0);// I/O wrap, unclaimed
      run_req(1'b0, 1'b0, 32'h0000_0071, 2'd1, 32'h0, 0, 3);        // lanes above size zero

      for (int k = 0; k < 40; k++) begin
         logic        m, w;
         logic [1:0]  s;
         logic [31:0] a;
         int          md, wt;
         m  = 1'($urandom);
         w  = 1'($urandom);
         s  = 2'($urandom % 3);
         a  = m ? ($urandom & 32'h00FF_FFFF) : $urandom;
         if ($urandom % 10 == 0) a = a | 32'h0200_0000;
         md = int'($urandom % 3);
         wt = int'($urandom % 3);
         run_req(w, m, a, s, $urandom, md, wt);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule